// File: doc/BRIEF.md
# Double to single precision narrowing unit

This unit takes a 64-bit IEEE double-precision bit pattern and produces the 32-bit single-precision word that a single-precision store would write to memory. It does no rounding. A value whose exponent is large enough, or whose magnitude is zero, is narrowed by selecting bit fields directly, and the result appears one cycle after the request is accepted. A value whose exponent falls in a narrow window just below the single-precision normal range becomes a single-precision denormal. To get there, the unit shifts the significand right by one bit per clock until the exponent reaches the single-precision minimum. Any other value gives an all-zero word.

A request is a one-cycle `start_i` pulse with the operand on `dbl_i`. `busy_o` is high while a denormal is being shifted, and a start that arrives during that time is dropped. Every accepted request produces exactly one single-cycle `done_o` pulse, with the result on `sgl_o`. `sgl_o` keeps that value until the next result.

Bit numbering in this document is LSB-first (bit 63 of `dbl_i` is the sign). The double-precision exponent E is `dbl_i[62:52]` and the fraction is `dbl_i[51:0]`.

Top module: `d2s_convert`

## Requirements
- R1: If E > 896, the result is `{dbl_i[63:62], dbl_i[58:29]}`.
- R2: If `dbl_i[62:0]` is zero, the same field selection applies, so the result is the sign in bit 31 with every other bit zero.
- R3: If 874 <= E <= 896, the significand `{1, dbl_i[51:0]}` (53 bits) is shifted right by N = 897 - E positions, with zeros entering at the top. The result is `{dbl_i[63], 8'h00, S[51:29]}`, where S is the shifted significand.
- R4: A request from R3 raises `done_o` exactly N+1 cycles after the clock edge that accepts it. N ranges from 1 to 23.
- R5: A request from R1, R2 or R6 raises `done_o` on the cycle right after the edge that accepts it, so requests on consecutive cycles give results on consecutive cycles.
- R6: Any other input (E below 874 with `dbl_i[62:0]` nonzero) gives an all-zero result.
- R7: A `start_i` pulse while `busy_o` is high is ignored: it produces no result and does not change the conversion in progress.
- R8: After reset, `done_o`, `busy_o` and `sgl_o` are zero. `done_o` pulses once for each accepted request and never otherwise.
- R9: `busy_o` is high from the edge that accepts a request from R3 until the edge that raises its `done_o`, and it falls on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, accepted when `busy_o` is low |
| dbl_i | input | 64 | Double-precision operand |
| busy_o | output | 1 | Denormal shifting in progress |
| done_o | output | 1 | One-cycle result strobe |
| sgl_o | output | 32 | Single-precision result |

## Verification
On every cycle, the assertions check several properties. The direct and out-of-range results appear one cycle after acceptance. Every `done_o` pulse traces back to an accepted start or to the end of a busy period. `busy_o` never stays high longer than 23 cycles and always ends together with `done_o`, which then carries a zero exponent field. The exact denormal fraction bits, the N+1 latency for each exponent in the window, and the dropping of starts during `busy_o` can only be shown by the bench's scenarios. The bench runs every request through a scoreboard that compares each result value and its arrival cycle.

// File: rtl/d2s_pkg.sv
package d2s_pkg;
  localparam int DBL_W      = 64;
  localparam int SGL_W      = 32;
  localparam int DEXP_W     = 11;
  localparam int DMAN_W     = 52;
  localparam int SEXP_W     = 8;
  localparam int SMAN_W     = 23;
  localparam int DIRECT_MIN = 897;   // smallest exponent copied by field selection
  localparam int DENORM_LO  = 874;   // smallest exponent still denormalized
  localparam int MAX_SHIFT  = DIRECT_MIN - DENORM_LO;
  localparam int CNT_W      = $clog2(MAX_SHIFT + 1);
  localparam int SIG_W      = DMAN_W + 1;

  typedef enum logic [1:0] {
    K_ZERO,
    K_DIRECT,
    K_DENORM
  } kind_e;
endpackage

// File: rtl/d2s_classify.sv
module d2s_classify
  import d2s_pkg::*;
(
  input  logic [DBL_W-1:0] dbl_i,
  output kind_e            kind_o,
  output logic [SGL_W-1:0] direct_o,
  output logic [CNT_W-1:0] shift_o,
  output logic [SIG_W-1:0] sig_o
);
  localparam int EXP_HI = DBL_W - 2;

  logic [DEXP_W-1:0] exp_w;
  logic [DEXP_W:0]   diff_w;
  logic              mag_zero;

  assign exp_w    = dbl_i[EXP_HI -: DEXP_W];
  assign mag_zero = (dbl_i[DBL_W-2:0] == '0);
  assign diff_w   = (DEXP_W+1)'(DIRECT_MIN) - {1'b0, exp_w};
  assign shift_o  = diff_w[CNT_W-1:0];
  assign sig_o    = {1'b1, dbl_i[DMAN_W-1:0]};
  assign direct_o = {dbl_i[DBL_W-1 -: 2], dbl_i[DBL_W-6 -: SGL_W-2]};

  always_comb begin
    if (exp_w >= DEXP_W'(DIRECT_MIN) || mag_zero)
      kind_o = K_DIRECT;
    else if (exp_w >= DEXP_W'(DENORM_LO))
      kind_o = K_DENORM;
    else
      kind_o = K_ZERO;
  end
endmodule

// File: rtl/d2s_shifter.sv
module d2s_shifter #(
  parameter int FRAC_W = 53,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [FRAC_W-1:0] frac_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              active_o,
  output logic              last_o,
  output logic [FRAC_W-1:0] frac_o
);
  logic [FRAC_W-1:0] frac_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      frac_q <= '0;
      cnt_q  <= '0;
    end else if (load_i) begin
      frac_q <= frac_i;
      cnt_q  <= cnt_i;
    end else if (cnt_q != '0) begin
      frac_q <= frac_q >> 1;
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign active_o = (cnt_q != '0);
  assign last_o   = (cnt_q == CNT_W'(1));
  assign frac_o   = frac_q >> 1;
endmodule

// File: rtl/d2s_convert.sv
module d2s_convert
  import d2s_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [63:0]      dbl_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [31:0]      sgl_o
);
  kind_e            kind_w;
  logic [SGL_W-1:0] direct_w;
  logic [CNT_W-1:0] shift_w;
  logic [SIG_W-1:0] sig_w;
  logic             accept_w, load_w, act_w, last_w;
  logic [SIG_W-1:0] frac_w;
  logic             sign_q, done_q;
  logic [SGL_W-1:0] sgl_q;

  d2s_classify u_cls (
    .dbl_i    (dbl_i),
    .kind_o   (kind_w),
    .direct_o (direct_w),
    .shift_o  (shift_w),
    .sig_o    (sig_w)
  );

  assign accept_w = start_i && !act_w;
  assign load_w   = accept_w && (kind_w == K_DENORM);

  d2s_shifter #(.FRAC_W(SIG_W), .CNT_W(CNT_W)) u_shf (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load_w),
    .frac_i   (sig_w),
    .cnt_i    (shift_w),
    .active_o (act_w),
    .last_o   (last_w),
    .frac_o   (frac_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sign_q <= 1'b0;
      done_q <= 1'b0;
      sgl_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (last_w) begin
        sgl_q  <= {sign_q, {SEXP_W{1'b0}}, frac_w[DMAN_W-1 -: SMAN_W]};
        done_q <= 1'b1;
      end else if (accept_w) begin
        case (kind_w)
          K_DIRECT: begin
            sgl_q  <= direct_w;
            done_q <= 1'b1;
          end
          K_DENORM: sign_q <= dbl_i[DBL_W-1];
          default: begin
            sgl_q  <= '0;
            done_q <= 1'b1;
          end
        endcase
      end
    end
  end

  assign busy_o = act_w;
  assign done_o = done_q;
  assign sgl_o  = sgl_q;
endmodule

// File: rtl/d2s_convert_chk.sv
module d2s_convert_chk
  import d2s_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        start_i,
  input logic [63:0] dbl_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] sgl_o
);
  logic [CNT_W-1:0] run_q;
  logic             acc;
  logic [10:0]      ex;

  assign acc = start_i && !busy_o;
  assign ex  = dbl_i[62:52];

  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else     run_q <= busy_o ? run_q + 1'b1 : '0;
  end

  a_r8_done_cause: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ($past(start_i && !busy_o) || $past(busy_o)));

  a_r1_direct_fields: assert property (@(posedge clk) disable iff (rst)
    (acc && ex > 11'd896) |=> (done_o && sgl_o == {$past(dbl_i[63:62]), $past(dbl_i[58:29])}));

  a_r6_out_of_range: assert property (@(posedge clk) disable iff (rst)
    (acc && ex < 11'd874 && dbl_i[62:0] != '0) |=> (done_o && sgl_o == '0));

  a_r9_busy_enter: assert property (@(posedge clk) disable iff (rst)
    (acc && ex >= 11'd874 && ex <= 11'd896) |=> (busy_o && !done_o));

  a_r9_busy_exit: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

  a_r3_denorm_exp_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (done_o && sgl_o[30:23] == 8'h00));

  a_r4_busy_bound: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> (run_q < CNT_W'(MAX_SHIFT)));
endmodule

bind d2s_convert d2s_convert_chk u_d2s_chk (
  .clk     (clk),
  .rst     (rst),
  .start_i (start_i),
  .dbl_i   (dbl_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sgl_o   (sgl_o)
);

// File: tb/d2s_convert_bench.sv
module d2s_convert_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [63:0] dbl_i = '0;
  logic        busy_o, done_o;
  logic [31:0] sgl_o;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit finished = 1'b0;

  logic [31:0] exp_q[$];
  int          lat_q[$];
  int          t0_q[$];
  string       tag_q[$];

  d2s_convert u_d2s_convert (
    .clk(clk), .rst(rst), .start_i(start_i), .dbl_i(dbl_i),
    .busy_o(busy_o), .done_o(done_o), .sgl_o(sgl_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic void chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endfunction

  function automatic logic [31:0] model(input logic [63:0] d, output int lat);
    int e;
    logic [52:0] f;
    e = int'(d[62:52]);
    lat = 1;
    if (e > 896 || d[62:0] == 0) return {d[63:62], d[58:29]};
    if (e >= 874) begin
      f = {1'b1, d[51:0]} >> (897 - e);
      lat = 897 - e + 1;
      return {d[63], 8'h00, f[51:29]};
    end
    return 32'h0;
  endfunction

  task automatic send(input logic [63:0] d, input string tag);
    int lat;
    logic [31:0] r;
    while (busy_o) @(negedge clk);
    r = model(d, lat);
    exp_q.push_back(r); lat_q.push_back(lat); t0_q.push_back(cyc); tag_q.push_back(tag);
    start_i = 1'b1; dbl_i = d;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  function automatic logic [63:0] mk(input bit s, input int e, input logic [51:0] m);
    return {s, 11'(e), m};
  endfunction

  always @(negedge clk) begin
    if (!rst && done_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected done", 64'(sgl_o), 64'h0);
      end else begin
        logic [31:0] ev;
        int el, t0;
        string tg;
        ev = exp_q.pop_front(); el = lat_q.pop_front();
        t0 = t0_q.pop_front(); tg = tag_q.pop_front();
        chk(sgl_o == ev, tg, 64'(sgl_o), 64'(ev));
        chk(cyc - t0 == el, {tg, " latency"}, 64'(cyc - t0), 64'(el));
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done_o == 0 && busy_o == 0 && sgl_o == 0, "R8 reset state", {31'h0, done_o, busy_o, sgl_o}, 64'h0);

    send(64'h3FF0_0000_0000_0000, "R1 one");
    send(64'hC009_21FB_5444_2D18, "R1 neg");
    send(mk(0, 897, 52'hA_BCDE_F012_3456), "R1 exp897");
    send(mk(1, 2047, 52'h8_0000_0000_0001), "R1 nan");
    send(64'h0, "R2 pos zero");
    send(64'h8000_0000_0000_0000, "R2 neg zero");
    send(mk(0, 873, 52'hF_FFFF_FFFF_FFFF), "R6 exp873");
    send(mk(1, 0, 52'h1), "R6 tiny");
    @(negedge clk);
    send(mk(0, 896, 52'h5_5555_5555_5555), "R3 exp896");
    chk(busy_o == 1'b1, "R9 busy after accept", 64'(busy_o), 64'h1);
    send(mk(1, 885, 52'hD_EADB_EEF1_2345), "R3 exp885");
    send(mk(0, 874, 52'hF_FFFF_FFFF_FFFF), "R4 exp874");
    start_i = 1'b1; dbl_i = 64'h3FF0_0000_0000_0000;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R7 busy kept", 64'(busy_o), 64'h1);
    send(mk(0, 880, 52'h0), "R4 exp880");
    send(64'h4014_0000_0000_0000, "R5 after denorm");
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R7 queue drained", 64'(exp_q.size()), 64'h0);
    chk(busy_o == 0 && done_o == 0, "R9 idle at end", {62'h0, busy_o, done_o}, 64'h0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule